// File: doc/BRIEF.md
# Clear-on-Read Event Interrupt Status Register

This block gathers seven single-cycle event pulses from a 10/100 Ethernet PHY into sticky pending flags. It drives one active-high interrupt request. The pending flags and their per-event enables live together in one 16-bit management register. The upper byte carries the flags. The lower byte carries the enables, and each enable sits eight bit positions below its flag. A read of the register returns every flag and then clears all of them together. An event that lands in the same cycle as that read is not lost: it is still pending after the clear.

The interrupt is asserted when three conditions hold: a flag is pending, the enable for that flag is set, and a global interrupt-enable input is high. The global input stands in for a separate control register. Management access uses a simple parallel port with an address, write data, and write and read strobes. Read data is combinational and is valid in the cycle of the read strobe. Serial management framing is left to the surrounding logic.

Event order, from the highest bit down to the lowest: energy detect, link status change, speed change, duplex change, auto-negotiation complete, false-carrier counter half-full, receive-error counter half-full. `ev_pulse[6]` is energy detect and `ev_pulse[0]` is receive-error half-full.

Top module: `evt_irq_status`

## Requirements
- R1: After a synchronous reset, every pending flag and every enable is 0, and `irq` is 0.
- R2: A high `ev_pulse[i]` sets pending bit i+8, visible from the next cycle, whether or not enable bit i is set.
- R3: A read (`reg_rd`=1) at address 0x12 returns, in the same cycle, pending flags in bits 14:8 and enables in bits 6:0. Bits 15 and 7 read 0.
- R4: A read at address 0x12 clears all pending flags on the next clock edge. The value returned by that read still shows them set.
- R5: An event arriving in the cycle of a clearing read is absent from that read's data and is pending after the clear.
- R6: A write (`reg_wr`=1) at address 0x12 loads `reg_wdata[6:0]` into the enables from the next cycle. Bits 15:7 of the write data have no effect.
- R7: `irq` = `glb_irq_en` AND the OR over i of (pending bit i+8 AND enable bit i). It is combinational on the current state.
- R8: A read or write at any other address returns read data 0 and leaves all flags and enables unchanged.
- R9: After a clearing read with no new enabled event, `irq` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Read data, valid in the read-strobe cycle |
| ev_pulse | input | 7 | One-cycle event pulses, bit 6 = energy detect, bit 0 = receive-error half-full |
| glb_irq_en | input | 1 | Global interrupt enable |
| irq | output | 1 | Active-high interrupt request |

## Verification
Read data and `irq` are combinational, so the bench samples them one time unit after it drives the inputs in that same cycle. Flag and enable updates from events, reads and writes land on the next rising edge. The bench's model therefore applies them only after that edge, and every consequence is checked in the following cycle. Directed sequences check the due cycle explicitly. Examples: a flag is absent in the cycle of its event and present one cycle later, and `irq` falls one cycle after a clearing read.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NUM_EV   = 7;
    localparam int REG_W    = 16;
    localparam int FLAG_LSB = 8;

    typedef logic [NUM_EV-1:0] ev_vec_t;

    // Register image: reserved, flags, reserved, enables (enable i sits 8 below flag i)
    typedef struct packed {
        logic    rsv_hi;
        ev_vec_t pend;
        logic    rsv_lo;
        ev_vec_t en;
    } status_word_t;

    typedef struct packed {
        logic rd_hit;
        logic wr_hit;
        logic rd_miss;
    } acc_t;

    function automatic status_word_t pack_word(ev_vec_t pend, ev_vec_t en);
        status_word_t w;
        w.rsv_hi = 1'b0;
        w.pend   = pend;
        w.rsv_lo = 1'b0;
        w.en     = en;
        return w;
    endfunction

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
    import irq_pkg::*;
#(
    parameter int              ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 5'h12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output acc_t              acc
);
    logic match;

    always_comb begin
        match       = (addr == REG_ADDR);
        acc.rd_hit  = rd & match;
        acc.wr_hit  = wr & match;
        acc.rd_miss = rd & ~match;
    end

endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank
    import irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ev_vec_t ev,
    input  logic    clr,
    output ev_vec_t pend
);
    for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                pend[g] <= 1'b0;
            else if (clr)
                pend[g] <= ev[g];
            else if (ev[g])
                pend[g] <= 1'b1;
        end
    end

    // R2: any event is pending in the following cycle
    a_r2_event_latches: assert property (@(posedge clk) disable iff (rst)
        (|ev) |=> ((pend & $past(ev)) == $past(ev)));

    // R4/R5: after a clear only the same-cycle events remain
    a_r4_clear_keeps_new: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pend == $past(ev)));

    // R8: without a clear no flag is lost
    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  ev_vec_t din,
    output ev_vec_t en
);
    always_ff @(posedge clk) begin
        if (rst)
            en <= '0;
        else if (load)
            en <= din;
    end

    // R6: a write updates the enables
    a_r6_write_loads: assert property (@(posedge clk) disable iff (rst)
        load |=> (en == $past(din)));

    // R8: enables only change on a decoded write
    a_r8_enable_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(en));

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
    import irq_pkg::*;
#(
    parameter int                ADDR_W   = 5,
    parameter logic [ADDR_W-1:0] REG_ADDR = 5'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_EV-1:0] ev_pulse,
    input  logic              glb_irq_en,
    output logic              irq
);
    acc_t         acc;
    ev_vec_t      pend;
    ev_vec_t      en;
    status_word_t word;
    logic         unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:NUM_EV];

    irq_addr_dec #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
        .addr (reg_addr),
        .rd   (reg_rd),
        .wr   (reg_wr),
        .acc  (acc)
    );

    irq_pending_bank u_pend (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev_pulse),
        .clr  (acc.rd_hit),
        .pend (pend)
    );

    irq_enable_reg u_en (
        .clk  (clk),
        .rst  (rst),
        .load (acc.wr_hit),
        .din  (reg_wdata[NUM_EV-1:0]),
        .en   (en)
    );

    always_comb begin
        word      = pack_word(pend, en);
        reg_rdata = acc.rd_hit ? REG_W'(word) : '0;
        irq       = glb_irq_en & (|(pend & en));
    end

    // R3: reserved positions never read as 1
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[REG_W-1] == 1'b0) && (reg_rdata[FLAG_LSB-1] == 1'b0));

    // R7: no interrupt without the global enable
    a_r7_global_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> glb_irq_en);

    // R8: reads elsewhere return zero
    a_r8_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        acc.rd_miss |-> (reg_rdata == '0));

    // R9: clearing read with no new event drops the request
    a_r9_irq_drops: assert property (@(posedge clk) disable iff (rst)
        (acc.rd_hit && ev_pulse == '0) |=> !irq);

endmodule

// File: tb/test_evt_irq_status.sv
module test_evt_irq_status;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_wr, reg_rd;
    logic [15:0] reg_rdata;
    logic [6:0]  ev_pulse;
    logic        glb_irq_en;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic [6:0]  m_pend, m_en;
    logic [15:0] last_rdata;
    logic        last_irq;

    always #5 clk = ~clk;

    evt_irq_status i_evt_irq_status (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .ev_pulse(ev_pulse), .glb_irq_en(glb_irq_en), .irq(irq)
    );

    function automatic logic [15:0] exp_rdata(logic [4:0] a, logic rd, logic [6:0] p, logic [6:0] e);
        if (rd && a == 5'h12) return {1'b0, p, 1'b0, e};
        return 16'h0000;
    endfunction

    function automatic logic exp_irq(logic g, logic [6:0] p, logic [6:0] e);
        return g & (|(p & e));
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(logic [4:0] a, logic [15:0] wd, logic wr, logic rd, logic [6:0] ev, logic g);
        @(negedge clk);
        reg_addr = a; reg_wdata = wd; reg_wr = wr; reg_rd = rd;
        ev_pulse = ev; glb_irq_en = g;
        #1;
        last_rdata = reg_rdata;
        last_irq   = irq;
        check((a == 5'h12) ? "R3 rdata" : "R8 rdata", reg_rdata, exp_rdata(a, rd, m_pend, m_en));
        check("R7 irq", {15'd0, irq}, {15'd0, exp_irq(g, m_pend, m_en)});
        @(posedge clk);
        if (rd && a == 5'h12) m_pend = ev;
        else                  m_pend = m_pend | ev;
        if (wr && a == 5'h12) m_en = wd[6:0];
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; reg_addr = '0; reg_wdata = '0; reg_wr = 0; reg_rd = 0;
        ev_pulse = '0; glb_irq_en = 0;
        m_pend = '0; m_en = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        cyc(5'h12, 16'h0, 0, 1, 7'h00, 1);
        check("R1 reset read", last_rdata, 16'h0000);
        check("R1 reset irq", {15'd0, last_irq}, 16'h0000);

        // R2: event latches with enable off, visible next cycle
        cyc(5'h00, 16'h0, 0, 0, 7'h40, 1);
        cyc(5'h12, 16'h0, 0, 1, 7'h00, 1);
        check("R2 latch", last_rdata, 16'h4000);
        check("R2 no irq while disabled", {15'd0, last_irq}, 16'h0000);

        // R6: write all ones, only enables load
        cyc(5'h12, 16'hFFFF, 1, 0, 7'h00, 1);
        cyc(5'h12, 16'h0, 0, 1, 7'h00, 1);
        check("R6 write mask", last_rdata, 16'h007F);

        // R8: write elsewhere ignored, read elsewhere 0 and no clear
        cyc(5'h11, 16'h0000, 1, 0, 7'h01, 1);
        cyc(5'h13, 16'h0, 0, 1, 7'h00, 1);
        check("R8 miss read", last_rdata, 16'h0000);
        check("R8 irq kept", {15'd0, last_irq}, 16'h0001);

        // R4/R5: clearing read with a same-cycle event
        cyc(5'h12, 16'h0, 0, 1, 7'h08, 1);
        check("R4 read shows flag", last_rdata, 16'h017F);
        cyc(5'h12, 16'h0, 0, 1, 7'h00, 1);
        check("R5 event survives clear", last_rdata, 16'h087F);

        // R9: irq drops after clearing read
        cyc(5'h00, 16'h0, 0, 0, 7'h00, 1);
        check("R9 irq low", {15'd0, last_irq}, 16'h0000);

        // R7: global enable gates
        cyc(5'h00, 16'h0, 0, 0, 7'h02, 0);
        cyc(5'h00, 16'h0, 0, 0, 7'h00, 0);
        check("R7 global off", {15'd0, last_irq}, 16'h0000);
        cyc(5'h00, 16'h0, 0, 0, 7'h00, 1);
        check("R7 global on", {15'd0, last_irq}, 16'h0001);

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [4:0]  a;
            logic [15:0] wd;
            a  = ($urandom % 3 == 0) ? 5'($urandom) : 5'h12;
            wd = 16'($urandom);
            cyc(a, wd, ($urandom % 5 == 0), ($urandom % 4 == 0),
                7'($urandom) & 7'($urandom), ($urandom % 6 != 0));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule